// File: doc/BRIEF.md
# Read-Priority Write Buffer with Forwarding

This block sits between a cache and main memory and holds pending stores. Stores go into a small in-order queue instead of going to memory at once. A single request port to memory is shared by reads and queued stores. A read that misses the queue takes that port ahead of any store that is waiting. Stores drain, oldest first, only in cycles when no missing read wants the port.

Every read first searches the queue. If one or more queued stores target the read address, the read is answered locally from the youngest of them, with no memory access. A read that finds nothing goes to memory and waits for the returned data. When the queue is full, new stores are held off and draining takes the port even while a read is waiting. This keeps the queue from stalling forever behind a stream of reads.

Top module: `wbuf_rdprio`

## Requirements
- R1: A store is accepted on a cycle with `wr_valid` and `wr_ready` both high. It is placed in the queue and does not reach memory in that cycle. `wr_ready` is high whenever fewer than DEPTH (4) stores are queued.
- R2: When a read misses the queue and the queue is not full, the memory request in that cycle is the read (`mem_we` = 0, `mem_addr` = `rd_addr`), even if stores are pending.
- R3: Queued stores leave in arrival order (`mem_we` = 1, with the oldest entry's address and data). This happens only in cycles where no read is using the memory port. After the queue drains, memory holds the last value stored to each address.
- R4: A read whose address matches queued stores returns the data of the youngest matching store.
- R5: A read that hits the queue is accepted without a memory read, and `rsp_valid` rises on the next cycle. While it is accepted, the port stays free for a store drain.
- R6: With DEPTH stores queued, `wr_ready` is low. A write drain is requested on the memory port even while a missing read is waiting, and that read is held off (`rd_ready` low).
- R7: After a read goes to memory, no memory request is made until `mem_rvalid`. `rsp_valid` is high on the cycle after `mem_rvalid`, with that cycle's `mem_rdata`.
- R8: After reset the queue is empty: `wr_ready` is 1, and `mem_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store request |
| wr_ready | output | 1 | Store accepted when high |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read accepted when high |
| rd_addr | input | AW | Read address |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DW | Read data |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 = write drain, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |

## Verification
The assertions assume that memory pulses `mem_rvalid` exactly once for each accepted read request, never for writes, and not before the request. They also assume `mem_ready` may change in any cycle. The bench memory model returns read data two cycles after acceptance, drives `mem_rvalid` only for reads, and drives `mem_ready` from a fixed or random pattern. The random stimulus keeps addresses within eight locations, so reads hit the queue often and queued entries often share an address.

// File: rtl/wbuf_rdprio.sv
module wbuf_rdprio #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] ea [DEPTH];
  logic [DW-1:0] ed [DEPTH];
  logic [PW-1:0] head;
  logic [CW-1:0] count;
  logic          waiting;

  logic          hit;
  logic [DW-1:0] hit_data;
  logic [PW-1:0] idx;

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    idx      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head + PW'(i);
      if (CW'(i) < count && ea[idx] == rd_addr) begin
        hit      = 1'b1;
        hit_data = ed[idx];
      end
    end
  end

  logic full, rd_mem, wr_drain, push, pop, rd_fire;
  logic [PW-1:0] tail;

  assign full      = (count == CW'(DEPTH));
  assign tail      = head + count[PW-1:0];
  assign rd_mem    = !waiting && rd_valid && !hit && !full;
  assign wr_drain  = !waiting && (count != '0) && !rd_mem;
  assign mem_valid = rd_mem || wr_drain;
  assign mem_we    = !rd_mem;
  assign mem_addr  = rd_mem ? rd_addr : ea[head];
  assign mem_wdata = ed[head];
  assign rd_ready  = !waiting && (hit || (!full && mem_ready));
  assign wr_ready  = !full;
  assign push      = wr_valid && !full;
  assign pop       = wr_drain && mem_ready;
  assign rd_fire   = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        ea[tail] <= wr_addr;
        ed[tail] <= wr_data;
      end
      if (pop) head <= head + PW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (rd_fire && hit) begin
        rsp_valid <= 1'b1;
        rsp_data  <= hit_data;
      end else if (rd_fire) begin
        waiting <= 1'b1;
      end else if (waiting && mem_rvalid) begin
        waiting   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= mem_rdata;
      end
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_read_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting && rd_valid && !hit && count < CW'(DEPTH)) |-> (mem_valid && !mem_we && mem_addr == rd_addr));
  p_hit_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && hit) |=> (rsp_valid && !waiting));
  p_full_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !waiting) |-> (mem_valid && mem_we && !wr_ready && !(rd_valid && !hit && rd_ready)));
  p_wait_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !mem_valid);
  p_rsp_from_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && mem_rvalid) |=> (rsp_valid && rsp_data == $past(mem_rdata)));
endmodule

// File: tb/wbuf_rdprio_tb.sv
module wbuf_rdprio_tb;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic wr_valid = 0, rd_valid = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic wr_ready, rd_ready, rsp_valid, mem_valid, mem_we, mem_ready;
  logic [15:0] rsp_data, mem_wdata;
  logic [7:0] mem_addr;
  logic mem_rvalid;
  logic [15:0] mem_rdata;

  wbuf_rdprio u_dut (.clk, .rst_n, .wr_valid, .wr_ready, .wr_addr, .wr_data,
    .rd_valid, .rd_ready, .rd_addr, .rsp_valid, .rsp_data, .mem_valid, .mem_ready,
    .mem_we, .mem_addr, .mem_wdata, .mem_rvalid, .mem_rdata);

  int mode = 0;
  logic rnd = 0;
  assign mem_ready = (mode == 1) || (mode == 2 && rnd);

  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  logic [7:0]  wq_a [64];
  logic [15:0] wq_d [64];
  int wq_h = 0, wq_t = 0, nreads = 0, mchecks = 0, merrs = 0;
  logic rd_pend = 0;
  logic [7:0] rd_a = 0;
  logic [15:0] exp_rsp = 0;
  logic have_exp = 0;

  always @(posedge clk) begin
    rnd <= ($urandom % 3) != 0;
    mem_rvalid <= rd_pend;
    mem_rdata  <= mem[rd_a];
    rd_pend    <= 1'b0;
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) begin mem[a] <= 0; shadow[a] <= 0; end
      mem_rvalid <= 1'b0;
    end else begin
      if (wr_valid && wr_ready) begin
        shadow[wr_addr] <= wr_data;
        wq_a[wq_t % 64] <= wr_addr;
        wq_d[wq_t % 64] <= wr_data;
        wq_t <= wq_t + 1;
      end
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mchecks <= mchecks + 1;
          if (wq_h == wq_t || mem_addr != wq_a[wq_h % 64] || mem_wdata != wq_d[wq_h % 64]) begin
            merrs <= merrs + 1;
            $display("FAIL R3 drain order: got %h=%h expected %h=%h", mem_addr, mem_wdata,
                     wq_a[wq_h % 64], wq_d[wq_h % 64]);
          end
          mem[mem_addr] <= mem_wdata;
          wq_h <= wq_h + 1;
        end else begin
          rd_pend <= 1'b1;
          rd_a <= mem_addr;
          nreads <= nreads + 1;
        end
      end
      if (rd_valid && rd_ready) begin
        exp_rsp <= shadow[rd_addr];
        have_exp <= 1'b1;
      end
      if (rsp_valid) begin
        mchecks <= mchecks + 1;
        if (!have_exp || rsp_data != exp_rsp) begin
          merrs <= merrs + 1;
          $display("FAIL R4 read data: got %h expected %h", rsp_data, exp_rsp);
        end
        if (!(rd_valid && rd_ready)) have_exp <= 1'b0;
      end
    end
  end

  int checks = 0, errs = 0;
  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s: got %0h expected %0h", tag, act, exp); end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic put(input logic [7:0] a, input logic [15:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d; step(); wr_valid = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs + merrs, checks + mchecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int r0;
    repeat (4) step();
    rst_n = 1; step();
    chk(wr_ready && !mem_valid && !rsp_valid, "R8 reset state", {wr_ready, mem_valid, rsp_valid}, 3'b100);

    mode = 0;
    put(8'd1, 16'h11); put(8'd1, 16'h22); put(8'd2, 16'h33);
    chk(mem[1] == 0, "R1 store held in queue", mem[1], 0);
    chk(wr_ready, "R1 ready below depth", wr_ready, 1);
    chk(mem_valid && mem_we && mem_addr == 1 && mem_wdata == 16'h11, "R3 oldest drain request", mem_wdata, 16'h11);

    r0 = nreads;
    rd_valid = 1; rd_addr = 1; #0;
    chk(rd_ready, "R5 hit accepted without memory", rd_ready, 1);
    chk(mem_valid && mem_we, "R5 port left to drain", mem_we, 1);
    step(); rd_valid = 0;
    chk(rsp_valid && rsp_data == 16'h22, "R4 youngest match", rsp_data, 16'h22);
    chk(nreads == r0, "R5 no memory read", nreads, r0);

    rd_valid = 1; rd_addr = 5; #0;
    chk(mem_valid && !mem_we && mem_addr == 5, "R2 read before pending stores", {mem_we, mem_addr}, 5);
    mode = 1;
    step(); rd_valid = 0;
    chk(!mem_valid, "R7 quiet while waiting", mem_valid, 0);
    step(); step();
    chk(rsp_valid && rsp_data == 0, "R7 memory response", rsp_data, 0);
    repeat (6) step();
    chk(mem[1] == 16'h22 && mem[2] == 16'h33, "R3 drained values", mem[1], 16'h22);

    mode = 0;
    put(8'd3, 16'h1); put(8'd4, 16'h2); put(8'd3, 16'h3); put(8'd4, 16'h4);
    chk(!wr_ready, "R6 full stalls stores", wr_ready, 0);
    wr_valid = 1; wr_addr = 7; wr_data = 16'h77;
    rd_valid = 1; rd_addr = 6; #0;
    chk(!rd_ready, "R6 read held off when full", rd_ready, 0);
    chk(mem_valid && mem_we && mem_addr == 3, "R6 drain despite waiting read", {mem_we, mem_addr}, 9'h103);
    mode = 1;
    step();
    chk(mem_valid && !mem_we && mem_addr == 6, "R2 read after one drain", {mem_we, mem_addr}, 6);
    step(); wr_valid = 0; rd_valid = 0;
    repeat (12) step();
    chk(mem[3] == 16'h3 && mem[4] == 16'h4 && mem[7] == 16'h77, "R3 full-buffer drain result", mem[7], 16'h77);

    mode = 2;
    for (int c = 0; c < 4000; c++) begin
      wr_valid = ($urandom % 3) == 0; wr_addr = 8'($urandom % 8); wr_data = 16'($urandom);
      rd_valid = ($urandom % 3) == 0; rd_addr = 8'($urandom % 8);
      step();
    end
    wr_valid = 0; rd_valid = 0; mode = 1;
    repeat (20) step();
    for (int a = 0; a < 8; a++)
      chk(mem[a] == shadow[a], "R3 final memory image", mem[a], shadow[a]);
    finish_run();
  end
endmodule